// File: doc/BRIEF.md
# Interconnect Error Detect and Capture

This unit sits beside a coherent interconnect and records the faults the fabric reports. The fabric presents one-cycle strobes for four error kinds (local access error, coherency violation, unavailable target, multicast stash). Each strobe comes with the 40-bit physical address of the offending transaction, its 8-bit requester ID, a 5-bit capture type and a 32-bit auxiliary attribute word. Each error kind can be masked from detection. A detected error sets a sticky status bit, and a separate per-kind enable decides whether that bit drives the level interrupt.

The first detected error after the capture slot is empty fills the slot with its address, requester ID, type and auxiliary word, and sets a capture-valid flag. The slot then stays frozen until software releases it. Software services the unit over a plain 32-bit register bus. It reads the status word and writes the same value back, which clears the reported kinds and releases the capture slot in a single access.

Top module: `icn_err_capture`

## Requirements
- R1: After synchronous active-low reset every register reads zero and `irq` is low.
- R2: A strobe on `err_strobe[k]` whose kind is not masked sets status bit k at offset 0x00 on the clock edge that samples it, and the bit stays set without further strobes. Bit 0 is local access error, bit 1 coherency violation, bit 2 unavailable target, bit 3 multicast stash.
- R3: A 1 in bit k of the mask register (offset 0x04, same bit positions) stops strobe k from setting status bit k. Writing 0 there re-enables every kind.
- R4: Writing 1 to any of bits 3:0 at offset 0x00 clears those status bits, and writing 0 leaves them alone. If a strobe for a bit arrives in the same cycle as its clearing write, the bit stays set.
- R5: `irq` is high exactly when some status bit 3:0 is set and the matching bit of the interrupt enable register (offset 0x08) is set. Clearing the enables silences `irq` but detection continues.
- R6: When no capture is held, the first detected error sets bit 31 of offset 0x00 and stores its type in bits 30:26 of offset 0x00. Its requester ID goes to bits 25:18 of offset 0x0C, address bits 39:32 to bits 7:0 of offset 0x10, address bits 31:0 to offset 0x14, and the auxiliary word to offset 0x18. When several kinds strobe in one cycle, one capture is taken from the shared inputs.
- R7: While capture-valid is set, later errors still set their status bits but leave the captured type, requester ID, address and auxiliary word unchanged.
- R8: Writing 1 to bit 31 of offset 0x00 clears capture-valid and the capture type. A detected error in that same cycle is captured at once.
- R9: Unused register bits and offsets other than the seven listed read zero. Writes to offsets 0x0C through 0x18 and to unlisted offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe | input | 4 | One-cycle error strobes, one per kind |
| err_addr | input | 40 | Physical address of the erring transaction |
| err_src | input | 8 | Requester ID of the erring transaction |
| err_kind | input | 5 | Capture type of the erring transaction |
| err_aux | input | 32 | Auxiliary attribute word |
| bus_wr | input | 1 | Register write strobe |
| bus_off | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_off`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Directed cases each separate a single rule. A masked strobe must leave no status bit behind. A strobe that meets its own clearing write must survive. A second error must not disturb a held capture, while a release and a new error in the same cycle must load the new one. Writes to capture registers and reads of the unlisted offset tell real registers from holes in the window. A long seeded random run then mixes sparse multi-bit strobes with writes to every offset, including random status write-backs that set or leave clear bit 31. This exercises the interplay of masking, clearing, interrupt gating and capture freezing in orders the directed cases never reach.

// File: rtl/icn_err_pkg.sv
// Shared widths, register offsets and field positions for the
// interconnect error detect and capture unit.
package icn_err_pkg;
    localparam int NTYPE    = 4;
    localparam int PADDR_W  = 40;
    localparam int SRC_W    = 8;
    localparam int KIND_W   = 5;
    localparam int AUX_W    = 32;
    localparam int DW       = 32;
    localparam int OFF_W    = 5;
    localparam int CAPV_BIT = 31;
    localparam int KIND_LSB = 26;
    localparam int SRC_LSB  = 18;
    localparam int HI_W     = PADDR_W - 32;

    localparam logic [OFF_W-1:0] OFF_STAT  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_MASK  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_IEN   = 5'h08;
    localparam logic [OFF_W-1:0] OFF_ATTR  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_AHI   = 5'h10;
    localparam logic [OFF_W-1:0] OFF_ALO   = 5'h14;
    localparam logic [OFF_W-1:0] OFF_ATTR2 = 5'h18;

    typedef struct packed {
        logic [KIND_W-1:0]  kind;
        logic [SRC_W-1:0]   src;
        logic [PADDR_W-1:0] addr;
        logic [AUX_W-1:0]   aux;
    } cap_rec_t;
endpackage

// File: rtl/icn_err_ctrl.sv
// Control registers: detection mask and interrupt enable, plus decode of
// status-register writes into clear pulses.
// Assumes single-cycle writes; reads have no side effects.
module icn_err_ctrl
    import icn_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data,
    output logic [NTYPE-1:0] mask,
    output logic [NTYPE-1:0] ien,
    output logic [NTYPE-1:0] stat_clr,
    output logic             cap_clr
);
    logic stat_wr;
    assign stat_wr = wr_en && (wr_off == OFF_STAT);

    // Write-one-to-clear pulses for the status word.
    always_comb begin
        stat_clr = stat_wr ? wr_data[NTYPE-1:0] : '0;
        cap_clr  = stat_wr && wr_data[CAPV_BIT];
    end

    // Mask and enable registers, loaded by whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            ien  <= '0;
        end else if (wr_en) begin
            if (wr_off == OFF_MASK) mask <= wr_data[NTYPE-1:0];
            if (wr_off == OFF_IEN)  ien  <= wr_data[NTYPE-1:0];
        end
    end

    // R9: a write elsewhere leaves the mask untouched
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off != OFF_MASK) |=> $stable(mask));
endmodule

// File: rtl/icn_err_status.sv
// Sticky per-kind status bits and the level interrupt.
// Assumes strobes last one cycle; a set and a clear in one cycle resolve to set.
module icn_err_status
    import icn_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTYPE-1:0] strobe,
    input  logic [NTYPE-1:0] mask,
    input  logic [NTYPE-1:0] ien,
    input  logic [NTYPE-1:0] clr,
    output logic [NTYPE-1:0] stat,
    output logic [NTYPE-1:0] hit,
    output logic             irq
);
    // Detection qualified by the mask.
    assign hit = strobe & ~mask;

    for (genvar k = 0; k < NTYPE; k++) begin : g_bit
        // Sticky bit: set by a detected error, cleared by a write of one.
        always_ff @(posedge clk) begin
            if (!rst_n) stat[k] <= 1'b0;
            else        stat[k] <= hit[k] | (stat[k] & ~clr[k]);
        end
    end

    // Interrupt from enabled status bits.
    assign irq = |(stat & ien);

    // R2: a detected error is recorded next cycle, whatever the write
    a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));
    // R3: a masked strobe never raises a clear bit
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe & mask & ~stat) != '0) |=> ((stat & $past(strobe & mask & ~stat)) == '0));
    // R4: a cleared bit with no strobe reads zero next cycle
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0 && strobe == '0) |=> ((stat & $past(clr)) == '0));
    // R2: without strobe or clear the status holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0 && strobe == '0) |=> $stable(stat));
endmodule

// File: rtl/icn_err_slot.sv
// Capture slot: records the first detected error and freezes until released.
// Assumes a release and a new error in one cycle load the new error.
module icn_err_slot
    import icn_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_hit,
    input  logic               cap_clr,
    input  logic [KIND_W-1:0]  ev_kind,
    input  logic [SRC_W-1:0]   ev_src,
    input  logic [PADDR_W-1:0] ev_addr,
    input  logic [AUX_W-1:0]   ev_aux,
    output logic               capv,
    output cap_rec_t           rec
);
    logic take;
    assign take = any_hit && (!capv || cap_clr);

    // Valid flag and type: set on capture, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capv     <= 1'b0;
            rec.kind <= '0;
        end else if (take) begin
            capv     <= 1'b1;
            rec.kind <= ev_kind;
        end else if (cap_clr) begin
            capv     <= 1'b0;
            rec.kind <= '0;
        end
    end

    // Address, requester and auxiliary word: loaded only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec.src  <= '0;
            rec.addr <= '0;
            rec.aux  <= '0;
        end else if (take) begin
            rec.src  <= ev_src;
            rec.addr <= ev_addr;
            rec.aux  <= ev_aux;
        end
    end

    // R6: a fresh capture holds the inputs of its cycle
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capv) |-> (rec.addr == $past(ev_addr) && rec.src == $past(ev_src)));
    // R7: a held capture is frozen until released
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (capv && !cap_clr) |=> (capv && $stable(rec)));
    // R8: release without a new error empties the slot
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_clr && !any_hit) |=> (!capv && rec.kind == '0));
endmodule

// File: rtl/icn_err_capture.sv
// Top of the interconnect error detect and capture unit: wires control,
// status and capture slot, and drives the combinational read mux.
// Assumes a byte-offset register bus with single-cycle writes.
module icn_err_capture
    import icn_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTYPE-1:0]   err_strobe,
    input  logic [PADDR_W-1:0] err_addr,
    input  logic [SRC_W-1:0]   err_src,
    input  logic [KIND_W-1:0]  err_kind,
    input  logic [AUX_W-1:0]   err_aux,
    input  logic               bus_wr,
    input  logic [OFF_W-1:0]   bus_off,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq
);
    logic [NTYPE-1:0] mask, ien, stat_clr, stat, hit;
    logic             cap_clr, capv;
    cap_rec_t         rec;

    icn_err_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_off(bus_off),
        .wr_data(bus_wdata), .mask(mask), .ien(ien),
        .stat_clr(stat_clr), .cap_clr(cap_clr)
    );

    icn_err_status u_stat (
        .clk(clk), .rst_n(rst_n), .strobe(err_strobe), .mask(mask),
        .ien(ien), .clr(stat_clr), .stat(stat), .hit(hit), .irq(irq)
    );

    icn_err_slot u_slot (
        .clk(clk), .rst_n(rst_n), .any_hit(|hit), .cap_clr(cap_clr),
        .ev_kind(err_kind), .ev_src(err_src), .ev_addr(err_addr),
        .ev_aux(err_aux), .capv(capv), .rec(rec)
    );

    // Read mux: unused bits and unlisted offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_off)
            OFF_STAT: begin
                bus_rdata[CAPV_BIT]                   = capv;
                bus_rdata[KIND_LSB +: KIND_W]         = rec.kind;
                bus_rdata[NTYPE-1:0]                  = stat;
            end
            OFF_MASK:  bus_rdata[NTYPE-1:0]           = mask;
            OFF_IEN:   bus_rdata[NTYPE-1:0]           = ien;
            OFF_ATTR:  bus_rdata[SRC_LSB +: SRC_W]    = rec.src;
            OFF_AHI:   bus_rdata[HI_W-1:0]            = rec.addr[PADDR_W-1:32];
            OFF_ALO:   bus_rdata                      = rec.addr[31:0];
            OFF_ATTR2: bus_rdata                      = rec.aux;
            default:   bus_rdata                      = '0;
        endcase
    end

    // R5: the interrupt never stands without an enabled status bit
    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat & ien) != '0));
    // R1: right after reset nothing is pending
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq && !capv));
endmodule

// File: tb/sim_icn_err_capture.sv
module sim_icn_err_capture;
    localparam int CLK_PERIOD = 40;
    localparam int N_RAND     = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  err_strobe = '0;
    logic [39:0] err_addr = '0;
    logic [7:0]  err_src = '0;
    logic [4:0]  err_kind = '0;
    logic [31:0] err_aux = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [3:0]  m_stat = '0, m_mask = '0, m_ien = '0;
    logic        m_capv = 1'b0;
    logic [4:0]  m_kind = '0;
    logic [7:0]  m_src = '0;
    logic [39:0] m_addr = '0;
    logic [31:0] m_aux = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icn_err_capture u0 (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_addr(err_addr),
        .err_src(err_src), .err_kind(err_kind), .err_aux(err_aux),
        .bus_wr(bus_wr), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] off);
        case (off)
            5'h00: return {m_capv, m_kind, 22'd0, m_stat};
            5'h04: return {28'd0, m_mask};
            5'h08: return {28'd0, m_ien};
            5'h0C: return {6'd0, m_src, 18'd0};
            5'h10: return {24'd0, m_addr[39:32]};
            5'h14: return m_addr[31:0];
            5'h18: return m_aux;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Reads every offset plus the hole at 0x1C and the interrupt.
    task automatic check_all(input string tag);
        bus_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bus_off = 5'(i * 4);
            #1;
            chk($sformatf("%s off %02h", tag, i * 4), bus_rdata, exp_read(5'(i * 4)));
        end
        chk($sformatf("%s irq (R5)", tag), {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
    endtask

    // One clock of stimulus; the model advances alongside.
    task automatic step(input string tag, input logic [3:0] s, input logic w,
                        input logic [4:0] a, input logic [31:0] d);
        logic [3:0] hit, clr;
        logic       rel, take;
        @(negedge clk);
        check_all(tag);
        err_strobe = s;
        err_addr   = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
        err_src    = 8'($urandom);
        err_kind   = 5'($urandom);
        err_aux    = $urandom;
        bus_wr = w; bus_off = a; bus_wdata = d;
        hit  = s & ~m_mask;
        clr  = (w && a == 5'h00) ? d[3:0] : 4'd0;
        rel  = w && a == 5'h00 && d[31];
        take = (|hit) && (!m_capv || rel);
        @(posedge clk);
        m_stat = (m_stat & ~clr) | hit;
        if (take) begin
            m_capv = 1'b1; m_kind = err_kind; m_src = err_src;
            m_addr = err_addr; m_aux = err_aux;
        end else if (rel) begin
            m_capv = 1'b0; m_kind = '0;
        end
        if (w && a == 5'h04) m_mask = d[3:0];
        if (w && a == 5'h08) m_ien  = d[3:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1 reset", 4'h0, 1'b0, 5'h00, 32'd0);
        // R2 R6: first error sets its bit and fills the slot
        step("R2 R6 first", 4'h1, 1'b0, 5'h00, 32'd0);
        // R7: second error sets its bit, capture frozen
        step("R6 seen", 4'h2, 1'b0, 5'h00, 32'd0);
        // R5: enable two kinds
        step("R7 frozen", 4'h0, 1'b1, 5'h08, 32'h3);
        step("R5 irq on", 4'h0, 1'b1, 5'h04, 32'h4);
        // R3: masked kind does not set its bit
        step("R3 mask set", 4'h4, 1'b0, 5'h00, 32'd0);
        // R4: strobe beats its own clear
        step("R3 masked", 4'h1, 1'b1, 5'h00, 32'h1);
        step("R4 strobe wins", 4'h0, 1'b1, 5'h00, 32'h8000_0003);
        // R8: release with no error empties the slot
        step("R8 released", 4'h0, 1'b1, 5'h08, 32'h0);
        // R5: enables cleared, detection continues
        step("R5 irq off", 4'h8, 1'b0, 5'h00, 32'd0);
        // R8: release and new error together recapture
        step("R5 detect only", 4'h2, 1'b1, 5'h00, 32'h8000_0000);
        // R9: writes to capture registers and the hole are ignored
        step("R8 recapture", 4'h0, 1'b1, 5'h14, 32'hDEAD_BEEF);
        step("R9 wr 14", 4'h0, 1'b1, 5'h0C, 32'hFFFF_FFFF);
        step("R9 wr 0C", 4'h0, 1'b1, 5'h1C, 32'hFFFF_FFFF);
        step("R9 wr 1C", 4'h0, 1'b1, 5'h04, 32'h0);
        step("R3 unmask", 4'h4, 1'b0, 5'h00, 32'd0);
        // Random mix across all requirements (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < N_RAND; n++) begin
            logic [3:0]  s;
            logic        w;
            logic [4:0]  a;
            logic [31:0] d;
            s = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
            w = ($urandom % 3 == 0);
            a = 5'(($urandom % 8) * 4);
            d = $urandom;
            if ($urandom % 2 == 0) a = 5'h00;
            step("RND", s, w, a, d);
        end
        @(negedge clk);
        check_all("final");
        finish_run();
    end
endmodule